// File: doc/BRIEF.md
# Test-Partitioned Sixteen-Bit Counter

This block is a synchronous up-counter whose count is held as two half-width sub-counters, eight bits each by default. In normal operation the halves chain into one sixteen-bit count: the lower half steps on the count enable and the upper half steps when the lower half wraps.

When the test-mode input is high, the link between the halves is cut. Each half then steps on its own test enable. A tester can therefore run every state of each half in a few hundred cycles, instead of walking the whole sixteen-bit range. A synchronous parallel load places the counter at any chosen value. Logic downstream can then be tested from a known count. A synchronous reset gives every test sequence a known starting state.

Each half has its own carry output, so the wraparound of each half can be watched on its own.

Top module: `pcnt_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, the count becomes 0 after that edge, whatever the other inputs are. Reset has priority over load.
- R2: While `rst` is low and `load` is high at an edge, the count becomes `load_val` after that edge. Load has priority over counting in both modes.
- R3: In normal mode (`test_mode` = 0), the lower half (`count[7:0]`) steps by one, modulo 256, at each edge where `cnt_en` is high. With `cnt_en` low, the whole count holds.
- R4: In normal mode, the upper half (`count[15:8]`) steps by one only at an edge where `cnt_en` is high and the lower half equals 8'hFF. The count therefore wraps from 16'hFFFF to 16'h0000.
- R5: In test mode (`test_mode` = 1), the lower half steps only on `tst_en_lo`, and `cnt_en` has no effect on either half.
- R6: In test mode, the upper half steps by one, modulo 256, on each edge where `tst_en_hi` is high, whatever value the lower half holds. Without `tst_en_hi`, the upper half holds, even when the lower half wraps.
- R7: `carry_lo` is high exactly when `rst` and `load` are low, the lower half equals 8'hFF, and the lower half's enable is active. That enable is `cnt_en` in normal mode and `tst_en_lo` in test mode. `carry_hi` follows the same rule for the upper half, using the upper half's enable. Both are combinational.
- R8: In normal mode, `tst_en_lo` and `tst_en_hi` have no effect on the count or on the carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count enable in normal mode |
| test_mode | input | 1 | 1 cuts the link between the halves |
| tst_en_lo | input | 1 | Lower-half enable in test mode |
| tst_en_hi | input | 1 | Upper-half enable in test mode |
| load | input | 1 | Parallel load strobe |
| load_val | input | 16 | Value taken on load |
| count | output | 16 | Current count |
| carry_lo | output | 1 | Lower half wraps at this edge |
| carry_hi | output | 1 | Upper half wraps at this edge |

## Verification
The hardest case to reach is a wrap of the upper half. Counting up from reset would take 65536 enabled cycles, so the stimulus preloads values just below each wrap point. Typical values are 16'hFFFF, 16'h00FF and 16'h12FF, applied in both modes. In addition, the random stimulus draws preload values near all-ones, so the random sequence crosses both wrap points many times and flips between the modes at those points.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;

    localparam int NUM_HALVES = 2;
    localparam int IDX_LO     = 0;
    localparam int IDX_HI     = 1;

    typedef struct packed {
        logic inc_hi;
        logic inc_lo;
    } half_en_t;

    typedef struct packed {
        logic test_mode;
        logic cnt_en;
        logic tst_en_lo;
        logic tst_en_hi;
    } ctl_t;

    function automatic half_en_t steer(input ctl_t c, input logic lo_wrap);
        half_en_t e;
        e.inc_lo = c.test_mode ? c.tst_en_lo : c.cnt_en;
        e.inc_hi = c.test_mode ? c.tst_en_hi : lo_wrap;
        return e;
    endfunction

endpackage

// File: rtl/pcnt_half.sv
module pcnt_half #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    output logic [W-1:0] q,
    output logic         carry
);
    localparam logic [W-1:0] TOP = {W{1'b1}};
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= load_val;
        else if (inc)  q <= q + ONE;
    end

    assign carry = !rst && !load && inc && (q == TOP);

    a_r2_load_value: assert property (@(posedge clk) disable iff (rst)
        load |=> q == $past(load_val));
    a_r3_step: assert property (@(posedge clk) disable iff (rst)
        (!load && inc) |=> q == $past(q) + ONE);
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (!load && !inc) |=> $stable(q));
    a_r7_wrap_zero: assert property (@(posedge clk) disable iff (rst)
        carry |=> q == '0);
endmodule

// File: rtl/pcnt_link.sv
module pcnt_link
    import pcnt_pkg::*;
(
    input  ctl_t     ctl,
    input  logic     lo_carry,
    output half_en_t en
);
    assign en = steer(ctl, lo_carry);

    always_comb begin
        if (ctl.test_mode)
            a_r6_hi_own_enable: assert (en.inc_hi == ctl.tst_en_hi);
    end
endmodule

// File: rtl/pcnt_top.sv
module pcnt_top
    import pcnt_pkg::*;
#(
    parameter int HALF_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cnt_en,
    input  logic                test_mode,
    input  logic                tst_en_lo,
    input  logic                tst_en_hi,
    input  logic                load,
    input  logic [2*HALF_W-1:0] load_val,
    output logic [2*HALF_W-1:0] count,
    output logic                carry_lo,
    output logic                carry_hi
);
    localparam int CNT_W = NUM_HALVES * HALF_W;

    ctl_t                  ctl;
    half_en_t              en;
    logic [NUM_HALVES-1:0] inc;
    logic [NUM_HALVES-1:0] carry;

    assign ctl = '{test_mode: test_mode, cnt_en: cnt_en,
                   tst_en_lo: tst_en_lo, tst_en_hi: tst_en_hi};
    assign inc[IDX_LO] = en.inc_lo;
    assign inc[IDX_HI] = en.inc_hi;

    pcnt_link u_link (
        .ctl      (ctl),
        .lo_carry (carry[IDX_LO]),
        .en       (en)
    );

    for (genvar i = 0; i < NUM_HALVES; i++) begin : g_half
        pcnt_half #(.W(HALF_W)) u_half (
            .clk      (clk),
            .rst      (rst),
            .load     (load),
            .load_val (load_val[i*HALF_W +: HALF_W]),
            .inc      (inc[i]),
            .q        (count[i*HALF_W +: HALF_W]),
            .carry    (carry[i])
        );
    end

    assign carry_lo = carry[IDX_LO];
    assign carry_hi = carry[IDX_HI];

    a_r1_reset_zero: assert property (@(posedge clk)
        rst |=> count == '0);
    a_r4_full_wrap: assert property (@(posedge clk) disable iff (rst)
        (!load && !test_mode && cnt_en && count == {CNT_W{1'b1}}) |=> count == '0);
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!load && !test_mode && !cnt_en) |=> $stable(count));
    a_r5_lo_ignores_cnt_en: assert property (@(posedge clk) disable iff (rst)
        (!load && test_mode && !tst_en_lo) |=> $stable(count[HALF_W-1:0]));
endmodule

// File: tb/pcnt_top_tb.sv
module pcnt_top_tb;
    logic        clk = 0;
    logic        rst = 1;
    logic        cnt_en = 0, test_mode = 0, tst_en_lo = 0, tst_en_hi = 0, load = 0;
    logic [15:0] load_val = 0;
    logic [15:0] count;
    logic        carry_lo, carry_hi;
    logic [15:0] exp_cnt = 0;
    int          n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    pcnt_top u_dut (.clk, .rst, .cnt_en, .test_mode, .tst_en_lo, .tst_en_hi,
                    .load, .load_val, .count, .carry_lo, .carry_hi);

    function automatic logic en_lo_f();
        return test_mode ? tst_en_lo : cnt_en;
    endfunction
    function automatic logic en_hi_f(input logic [15:0] c);
        return test_mode ? tst_en_hi : (cnt_en && c[7:0] == 8'hFF);
    endfunction
    function automatic logic [15:0] next_f(input logic [15:0] c);
        logic [7:0] lo, hi;
        if (rst) return 16'h0;
        if (load) return load_val;
        lo = c[7:0] + {7'd0, en_lo_f()};
        hi = c[15:8] + {7'd0, en_hi_f(c)};
        return {hi, lo};
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // inputs already driven after a negedge; check carries, clock, check count
    task automatic step(input string tag);
        logic cl, ch;
        #1;
        cl = !rst && !load && en_lo_f() && exp_cnt[7:0] == 8'hFF;
        ch = !rst && !load && en_hi_f(exp_cnt) && exp_cnt[15:8] == 8'hFF;
        check({tag, " R7 carry_lo"}, {15'd0, carry_lo}, {15'd0, cl});
        check({tag, " R7 carry_hi"}, {15'd0, carry_hi}, {15'd0, ch});
        @(posedge clk);
        exp_cnt = next_f(exp_cnt);
        @(negedge clk);
        check(tag, count, exp_cnt);
    endtask

    task automatic set(input logic r, ld, input logic [15:0] v, input logic tm, en, tl, th);
        rst = r; load = ld; load_val = v; test_mode = tm; cnt_en = en; tst_en_lo = tl; tst_en_hi = th;
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        set(1, 1, 16'hABCD, 0, 1, 1, 1); step("R1 reset over load");
        set(0, 0, 16'h0, 0, 0, 0, 0);    step("R3 hold after reset");
        set(0, 1, 16'h1234, 0, 1, 0, 0); step("R2 load over count");
        set(0, 0, 16'h0, 0, 1, 0, 0);    step("R3 lower step");
        set(0, 1, 16'hFFFF, 0, 0, 0, 0); step("R2 load FFFF");
        set(0, 0, 16'h0, 0, 1, 0, 0);    step("R4 full wrap");
        set(0, 1, 16'h12FF, 0, 0, 0, 0); step("R2 load 12FF");
        set(0, 0, 16'h0, 0, 1, 0, 0);    step("R4 upper step on lower wrap");
        set(0, 1, 16'h00FF, 0, 0, 0, 0); step("R2 load 00FF");
        set(0, 0, 16'h0, 1, 1, 1, 0);    step("R5 lower wraps, upper isolated");
        check("R6 upper unchanged", count, 16'h0000);
        set(0, 0, 16'h0, 1, 1, 0, 1);    step("R6 upper own enable");
        check("R5 cnt_en ignored", count, 16'h0100);
        set(0, 1, 16'hFF00, 0, 0, 0, 0); step("R2 load FF00");
        set(0, 0, 16'h0, 1, 0, 0, 1);    step("R6 upper wrap in test mode");
        set(0, 0, 16'h0, 0, 0, 1, 1);    step("R8 test enables ignored");
        check("R8 count still zero", count, 16'h0000);
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r = $urandom;
            logic [15:0] v = r[20] ? {8'hFF, 5'h1F, r[2:0]} : r[31:16];
            set(r[15:8] == 8'd0, r[7:4] == 4'd0, v, r[9], r[10] | r[11], r[12], r[13]);
            step(test_mode ? "R5 R6 random test mode" : "R3 R4 R8 random normal mode");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule